// File: doc/BRIEF.md
# Receive Word Buffer with Split Data/Status Readout

This block sits between a serial-line decoder and a processor. The decoder pushes each received 11-bit word into a small first-in first-out buffer. The processor reads the oldest word through two registers. The data register carries the low eight bits of the word. The status register carries the three upper bits in its low positions. A data-available flag tells the processor that a word is waiting.

Only a read of the data register removes a word from the buffer. Software must therefore read the status register before the data register. A select input switches the data bus over to an externally supplied error code. While that switch is set, data reads leave the buffer untouched. A write into a full buffer is dropped, and it sets a sticky overrun flag. Reset clears that flag.

Top module: `rx_word_fifo`

## Requirements
- R1: With `err_sel` low, `rd_bus` shows bits 7:0 of the oldest stored word, and it shows 8'h00 while the buffer is empty. Words leave in the order they were written.
- R2: A cycle with `rd_stat_stb` high loads bits 10:8 of the oldest word into `stat_bus[2:0]` at that clock edge. It loads 3'b000 if the buffer is empty. Otherwise `stat_bus` holds its value.
- R3: A cycle with `rd_data_stb` high, `err_sel` low and at least one word stored removes the oldest word at that clock edge.
- R4: A status read alone changes neither the occupancy nor the oldest word.
- R5: `data_avail` is high exactly while at least one word is stored. It falls right after the clock edge that removes the last word.
- R6: With `err_sel` high, `rd_bus` shows `err_code`, and a data read does not remove a word.
- R7: A write while three words are stored and no word is removed in the same cycle is discarded, and it sets `overrun`. `overrun` stays set until reset.
- R8: A write and a removal in the same cycle leave the occupancy unchanged. This also holds when the buffer is full, and in that case the new word is kept.
- R9: Synchronous active-low reset empties the buffer and clears `overrun` and `stat_bus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe from the decoder |
| wr_word | input | 11 | Received word |
| rd_data_stb | input | 1 | Data register read strobe |
| rd_stat_stb | input | 1 | Status register read strobe |
| err_sel | input | 1 | Selects the error code onto the read bus |
| err_code | input | 8 | Error code value |
| rd_bus | output | 8 | Read data bus |
| stat_bus | output | 3 | Status register low bits |
| data_avail | output | 1 | A word is waiting |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench fills the buffer to its three-entry limit and then writes once more. A design that wrapped or overwrote the oldest word would show the wrong head or leave `overrun` clear. A write together with a removal on a full buffer is checked separately. A design that refused that write would lose a word, and one that counted both events would go empty too early. Status reads and data reads with the error code selected are each followed by checks of the head and the flag. A design that let either of those reads remove a word would show the next word instead.

// File: rtl/rxf_pkg.sv
// Package: shared default sizes for the receive word buffer.
// Assumes words carry a data byte in their low bits and status above it.
package rxf_pkg;
    localparam int RXF_WORD_W = 11;
    localparam int RXF_DATA_W = 8;
    localparam int RXF_DEPTH  = 3;
endpackage

// File: rtl/rxf_store.sv
// Module: circular storage for the buffered words.
// Assumes push and pop are already qualified by the controller
// (no push into a full store unless a pop happens in the same cycle).
module rxf_store #(
    parameter int WORD_W = rxf_pkg::RXF_WORD_W,
    parameter int DEPTH  = rxf_pkg::RXF_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] head
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    logic [WORD_W-1:0] mem [DEPTH];

    // Advance the write pointer on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wptr <= '0;
        else if (push)
            wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
    end

    // Advance the read pointer on each removal.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rptr <= '0;
        else if (pop)
            rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Capture the incoming word into the slot the write pointer names.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (push && (wptr == PTR_W'(i)))
                mem[i] <= wdata;
        end
    end

    // Present the oldest slot.
    always_comb head = mem[rptr];
endmodule

// File: rtl/rxf_ctrl.sv
// Module: occupancy, flags and qualification of writes and removals.
// Assumes the strobes last one cycle per access.
module rxf_ctrl #(
    parameter int DEPTH = rxf_pkg::RXF_DEPTH,
    parameter int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_data_stb,
    input  logic             err_sel,
    output logic             push,
    output logic             pop,
    output logic [OCC_W-1:0] occ,
    output logic             not_empty,
    output logic             overrun
);
    localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

    // Decide which requested transfers are allowed this cycle.
    always_comb begin
        not_empty = (occ != '0);
        pop       = rd_data_stb && !err_sel && not_empty;
        push      = wr_en && ((occ != FULL) || pop);
    end

    // Track how many words are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            occ <= '0;
        else if (push && !pop)
            occ <= occ + 1'b1;
        else if (pop && !push)
            occ <= occ - 1'b1;
    end

    // Latch a dropped write until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (wr_en && !push)
            overrun <= 1'b1;
    end
endmodule

// File: rtl/rxf_readmux.sv
// Module: read-side presentation: data bus selection and status holding register.
// Assumes head is only meaningful while not_empty is high.
module rxf_readmux #(
    parameter int WORD_W = rxf_pkg::RXF_WORD_W,
    parameter int DATA_W = rxf_pkg::RXF_DATA_W,
    parameter int STAT_W = WORD_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] head,
    input  logic              not_empty,
    input  logic              err_sel,
    input  logic [DATA_W-1:0] err_code,
    input  logic              rd_stat_stb,
    output logic [DATA_W-1:0] rd_bus,
    output logic [STAT_W-1:0] stat_bus
);
    // Choose the error code or the head byte for the data bus.
    always_comb begin
        if (err_sel)
            rd_bus = err_code;
        else if (not_empty)
            rd_bus = head[DATA_W-1:0];
        else
            rd_bus = '0;
    end

    // Load the upper word bits when software reads the status register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_bus <= '0;
        else if (rd_stat_stb)
            stat_bus <= not_empty ? head[WORD_W-1:DATA_W] : '0;
    end
endmodule

// File: rtl/rx_word_fifo.sv
// Module: top of the receive word buffer with split data/status readout.
// Assumes one write per cycle at most from the decoder and single-cycle read strobes.
module rx_word_fifo #(
    parameter int WORD_W = rxf_pkg::RXF_WORD_W,
    parameter int DATA_W = rxf_pkg::RXF_DATA_W,
    parameter int DEPTH  = rxf_pkg::RXF_DEPTH
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [WORD_W-1:0]        wr_word,
    input  logic                     rd_data_stb,
    input  logic                     rd_stat_stb,
    input  logic                     err_sel,
    input  logic [DATA_W-1:0]        err_code,
    output logic [DATA_W-1:0]        rd_bus,
    output logic [WORD_W-DATA_W-1:0] stat_bus,
    output logic                     data_avail,
    output logic                     overrun
);
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic              push;
    logic              pop;
    logic              not_empty;
    logic [OCC_W-1:0]  occ;
    logic [WORD_W-1:0] head;

    rxf_ctrl #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data_stb(rd_data_stb),
        .err_sel(err_sel), .push(push), .pop(pop), .occ(occ),
        .not_empty(not_empty), .overrun(overrun)
    );

    rxf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wdata(wr_word), .head(head)
    );

    rxf_readmux #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_rmux (
        .clk(clk), .rst_n(rst_n), .head(head), .not_empty(not_empty),
        .err_sel(err_sel), .err_code(err_code), .rd_stat_stb(rd_stat_stb),
        .rd_bus(rd_bus), .stat_bus(stat_bus)
    );

    // Flag a waiting word to the processor.
    always_comb data_avail = not_empty;
endmodule

// File: rtl/rx_word_fifo_chk.sv
// Module: temporal checks on the receive word buffer, bound to its top.
// Assumes it observes the top's ports and its occupancy count.
module rx_word_fifo_chk #(
    parameter int DEPTH = rxf_pkg::RXF_DEPTH,
    parameter int OCC_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_data_stb,
    input logic             rd_stat_stb,
    input logic             err_sel,
    input logic             data_avail,
    input logic             overrun,
    input logic [OCC_W-1:0] occ
);
    p_avail_after_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> data_avail);

    p_pop_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_stb && !err_sel && data_avail && !wr_en) |=> (occ == $past(occ) - 1'b1));

    p_stat_no_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_stb && !rd_data_stb && !wr_en) |=> $stable(occ));

    p_last_pop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_W'(1) && rd_data_stb && !err_sel && !wr_en) |=> !data_avail);

    p_err_no_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sel && rd_data_stb && !wr_en) |=> $stable(occ));

    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_W'(DEPTH) && wr_en && !(rd_data_stb && !err_sel)) |=> overrun);

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    p_swap_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_data_stb && !err_sel && data_avail) |=> $stable(occ));
endmodule

bind rx_word_fifo rx_word_fifo_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data_stb(rd_data_stb),
    .rd_stat_stb(rd_stat_stb), .err_sel(err_sel), .data_avail(data_avail),
    .overrun(overrun), .occ(occ)
);

// File: tb/rx_word_fifo_test.sv
module rx_word_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [10:0] wr_word = '0;
    logic        rd_data_stb = 1'b0;
    logic        rd_stat_stb = 1'b0;
    logic        err_sel = 1'b0;
    logic [7:0]  err_code = '0;
    logic [7:0]  rd_bus;
    logic [2:0]  stat_bus;
    logic        data_avail;
    logic        overrun;

    int checks = 0;
    int errors = 0;

    rx_word_fifo uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb), .err_sel(err_sel),
        .err_code(err_code), .rd_bus(rd_bus), .stat_bus(stat_bus),
        .data_avail(data_avail), .overrun(overrun)
    );

    always #5 clk = ~clk;

    // Vector: {wr, word[10:0], rd, exp_avail, exp_head[7:0], exp_overrun}
    localparam int NV = 10;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 11'h5A3, 1'b0, 1'b1, 8'hA3, 1'b0},
        {1'b1, 11'h2C4, 1'b0, 1'b1, 8'hA3, 1'b0},
        {1'b0, 11'h000, 1'b1, 1'b1, 8'hC4, 1'b0},
        {1'b1, 11'h711, 1'b1, 1'b1, 8'h11, 1'b0},
        {1'b1, 11'h0FF, 1'b0, 1'b1, 8'h11, 1'b0},
        {1'b1, 11'h100, 1'b0, 1'b1, 8'h11, 1'b0},
        {1'b1, 11'h3EE, 1'b0, 1'b1, 8'h11, 1'b1},
        {1'b0, 11'h000, 1'b1, 1'b1, 8'hFF, 1'b1},
        {1'b0, 11'h000, 1'b1, 1'b1, 8'h00, 1'b1},
        {1'b0, 11'h000, 1'b1, 1'b0, 8'h00, 1'b1}
    };

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", what, act, exp);
        end
    endtask

    // One access cycle; inputs drop after the edge, then outputs settle.
    task automatic step(input logic wr, input logic [10:0] w, input logic rd,
                        input logic st, input logic es);
        @(negedge clk);
        wr_en = wr; wr_word = w; rd_data_stb = rd; rd_stat_stb = st; err_sel = es;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_data_stb = 1'b0; rd_stat_stb = 1'b0; err_sel = 1'b0;
        #1;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset avail", 32'(data_avail), 0);
        check("R9 reset overrun", 32'(overrun), 0);
        check("R9 reset stat", 32'(stat_bus), 0);
        check("R1 empty bus", 32'(rd_bus), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R3 R5 R7 R8 table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][22], VEC[i][21:11], VEC[i][10], 1'b0, 1'b0);
            check($sformatf("R5 vec %0d avail", i), 32'(data_avail), 32'(VEC[i][9]));
            check($sformatf("R1 R3 vec %0d head", i), 32'(rd_bus), 32'(VEC[i][8:1]));
            check($sformatf("R7 vec %0d overrun", i), 32'(overrun), 32'(VEC[i][0]));
        end

        // R9: reset clears overrun and empties
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R9 overrun cleared", 32'(overrun), 0);
        check("R9 emptied", 32'(data_avail), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 R4: status read loads upper bits and does not remove
        step(1'b1, 11'h5A3, 1'b0, 1'b0, 1'b0);
        step(1'b0, 11'h000, 1'b0, 1'b1, 1'b0);
        check("R2 stat bits", 32'(stat_bus), 32'h5);
        check("R4 head kept", 32'(rd_bus), 32'hA3);
        check("R4 avail kept", 32'(data_avail), 1);
        step(1'b0, 11'h000, 1'b0, 1'b0, 1'b0);
        check("R2 stat holds", 32'(stat_bus), 32'h5);

        // R6: error code on bus, data read does not remove
        @(negedge clk); err_sel = 1'b1; err_code = 8'h3C; #1;
        check("R6 err on bus", 32'(rd_bus), 32'h3C);
        step(1'b0, 11'h000, 1'b1, 1'b0, 1'b1);
        check("R6 no pop head", 32'(rd_bus), 32'hA3);
        check("R6 no pop avail", 32'(data_avail), 1);

        // R3 R5 R2: last removal clears flag; status of empty is zero
        step(1'b0, 11'h000, 1'b1, 1'b0, 1'b0);
        check("R5 last pop clears", 32'(data_avail), 0);
        step(1'b0, 11'h000, 1'b0, 1'b1, 1'b0);
        check("R2 empty stat", 32'(stat_bus), 0);

        // R8: write with removal on a full buffer keeps the new word
        step(1'b1, 11'h001, 1'b0, 1'b0, 1'b0);
        step(1'b1, 11'h002, 1'b0, 1'b0, 1'b0);
        step(1'b1, 11'h003, 1'b0, 1'b0, 1'b0);
        step(1'b1, 11'h604, 1'b1, 1'b0, 1'b0);
        check("R8 no overrun", 32'(overrun), 0);
        check("R8 head after swap", 32'(rd_bus), 32'h02);
        step(1'b0, 11'h000, 1'b1, 1'b0, 1'b0);
        check("R8 second", 32'(rd_bus), 32'h03);
        step(1'b0, 11'h000, 1'b0, 1'b1, 1'b0);
        check("R8 R2 kept word stat", 32'(stat_bus), 0);
        step(1'b0, 11'h000, 1'b1, 1'b0, 1'b0);
        check("R8 kept word", 32'(rd_bus), 32'h04);
        step(1'b0, 11'h000, 1'b0, 1'b1, 1'b0);
        check("R8 R2 new word stat", 32'(stat_bus), 32'h6);
        step(1'b0, 11'h000, 1'b1, 1'b0, 1'b0);
        check("R8 occupancy", 32'(data_avail), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule